// File: doc/BRIEF.md
# Three-Step Karatsuba 256-bit Multiplier

This block forms the full 512-bit unsigned product of two 256-bit operands. It splits each operand into a high and a low 128-bit half and uses one level of Karatsuba-Ofman decomposition. As a result, only three half-size products are needed instead of four.

All three products pass through a single shared multiplier that is 129 bits on each side. They are formed over three consecutive clock cycles, with adders between the cycles:

- **First step:** the two high halves are multiplied. The half-sums of each operand are registered.
- **Second step:** the two low halves are multiplied. The negated sum of both products is prepared for the third step.
- **Third step:** the two half-sums are multiplied. This cross product is combined with the stored terms to give the upper 384 bits of the result.

A requester drives the operands with a one-cycle start pulse while the block is idle. It then waits for the one-cycle done pulse. The product stays on the output until the next result replaces it.

Top module: `karatsuba_mul256`

## Requirements
- R1: When done_o is high, c_o equals the exact unsigned product a_i × b_i of the operands captured at the accepted start (512 bits, no truncation).
- R2: When start_i is sampled high at a rising edge while the block is idle, done_o is high for exactly one cycle, after the third rising edge that follows.
- R3: A start_i sampled high while busy_o is high is ignored. No extra done_o follows, and the result in flight still belongs to the operands first captured.
- R4: c_o changes only in the cycle done_o rises. At all other times it holds the last product.
- R5: While rst is high and in the first cycle after it, busy_o and done_o are low and c_o is zero.
- R6: busy_o is high for the three cycles after an accepted start and low otherwise. A new start is accepted in the cycle done_o is high.
- R7: Operands with all-ones or zero halves give exact results. This covers the carry out of the 129-bit half-sums and a middle term of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request; accepted only when idle |
| a_i | input | 256 | Multiplicand, sampled on accepted start |
| b_i | input | 256 | Multiplier, sampled on accepted start |
| busy_o | output | 1 | High during the three computation steps |
| done_o | output | 1 | One-cycle pulse when c_o holds a new product |
| c_o | output | 512 | Registered product |

## Verification
The internal state most likely to be wrong is the width or sign of the middle term, or the carry out of a half-sum. Either shows up as a wrong upper 384 bits of c_o, in the very cycle done_o rises. The lower 128 bits would still be correct, so operands with saturated halves are the ones that expose such faults.

A step counter that skips or repeats shows up at the ports as a done_o pulse on the wrong cycle or a busy_o of the wrong length. The bench compares both signals against its model on every clock, so this is seen within four cycles of a start. A start that is wrongly accepted while busy shows up as an extra done_o pulse, or as a product of the wrong operands.

// File: rtl/kmul_pkg.sv
package kmul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HIGH  = 2'd1,
    ST_LOW   = 2'd2,
    ST_CROSS = 2'd3
  } kstep_e;
endpackage

// File: rtl/kmul_submul.sv
// Shared square sub-multiplier; purely combinational, registered by the caller.
module kmul_submul #(
  parameter int SUB_W = 129
) (
  input  logic [SUB_W-1:0]   x_i,
  input  logic [SUB_W-1:0]   y_i,
  output logic [2*SUB_W-1:0] p_o
);
  localparam int PROD_W = 2 * SUB_W;

  logic [PROD_W-1:0] xw, yw;

  always_comb begin
    xw  = {{SUB_W{1'b0}}, x_i};
    yw  = {{SUB_W{1'b0}}, y_i};
    p_o = xw * yw;
  end
endmodule

// File: rtl/kmul_seq.sv
// Step sequencer: idle -> high product -> low product -> cross product.
module kmul_seq
  import kmul_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start_i,
  output kstep_e step_o,
  output logic   accept_o,
  output logic   busy_o,
  output logic   done_o
);
  kstep_e step_q, step_d;
  logic   done_q;

  assign accept_o = start_i && (step_q == ST_IDLE);

  always_comb begin
    step_d = step_q;
    case (step_q)
      ST_IDLE:  if (start_i) step_d = ST_HIGH;
      ST_HIGH:  step_d = ST_LOW;
      ST_LOW:   step_d = ST_CROSS;
      ST_CROSS: step_d = ST_IDLE;
      default:  step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= (step_q == ST_CROSS);
    end
  end

  assign step_o = step_q;
  assign busy_o = (step_q != ST_IDLE);
  assign done_o = done_q;

  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_cross_then_done_R2: assert property (@(posedge clk) disable iff (rst)
    (step_o == ST_CROSS) |=> done_o);

  assert_accept_busy_R6: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> (busy_o && step_o == ST_HIGH));

  assert_no_accept_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_o && step_o != ST_CROSS) |=> busy_o);

  assert_reset_quiet_R5: assert property (@(posedge clk)
    $past(rst) |-> (!done_o && !busy_o));
endmodule

// File: rtl/karatsuba_mul256.sv
// 256x256 unsigned multiplier, one Karatsuba level, three steps on one sub-multiplier.
module karatsuba_mul256
  import kmul_pkg::*;
#(
  parameter int HALF_W = 128
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [2*HALF_W-1:0]   a_i,
  input  logic [2*HALF_W-1:0]   b_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [4*HALF_W-1:0]   c_o
);
  localparam int OP_W   = 2 * HALF_W;
  localparam int SUB_W  = HALF_W + 1;
  localparam int PROD_W = 2 * SUB_W;
  localparam int TOP_W  = 3 * HALF_W;
  localparam int RES_W  = 4 * HALF_W;

  kstep_e step;
  logic   accept;

  kmul_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .step_o  (step),
    .accept_o(accept),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  // Captured operands and intermediate terms
  logic [OP_W-1:0]    a_q, b_q;
  logic [SUB_W-1:0]   asum_q, bsum_q;
  logic [OP_W-1:0]    hi_prod_q, lo_prod_q;
  logic [PROD_W-1:0]  negsum_q;
  logic [RES_W-1:0]   c_q;

  // Shared multiplier operand selection
  logic [SUB_W-1:0]   mx, my;
  logic [PROD_W-1:0]  mp;

  always_comb begin
    case (step)
      ST_HIGH: begin
        mx = {1'b0, a_q[OP_W-1:HALF_W]};
        my = {1'b0, b_q[OP_W-1:HALF_W]};
      end
      ST_LOW: begin
        mx = {1'b0, a_q[HALF_W-1:0]};
        my = {1'b0, b_q[HALF_W-1:0]};
      end
      ST_CROSS: begin
        mx = asum_q;
        my = bsum_q;
      end
      default: begin
        mx = '0;
        my = '0;
      end
    endcase
  end

  kmul_submul #(.SUB_W(SUB_W)) u_mul (
    .x_i(mx),
    .y_i(my),
    .p_o(mp)
  );

  // Step-boundary adders
  logic [SUB_W-1:0]  asum_d, bsum_d;
  logic [PROD_W-1:0] outer_sum, mid_term;
  logic [TOP_W-1:0]  top_part;

  always_comb begin
    asum_d    = {1'b0, a_q[OP_W-1:HALF_W]} + {1'b0, a_q[HALF_W-1:0]};
    bsum_d    = {1'b0, b_q[OP_W-1:HALF_W]} + {1'b0, b_q[HALF_W-1:0]};
    outer_sum = mp + {2'b00, hi_prod_q};
    mid_term  = mp + negsum_q;
    top_part  = {hi_prod_q, lo_prod_q[OP_W-1:HALF_W]}
              + {{(TOP_W-PROD_W){1'b0}}, mid_term};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q       <= '0;
      b_q       <= '0;
      asum_q    <= '0;
      bsum_q    <= '0;
      hi_prod_q <= '0;
      lo_prod_q <= '0;
      negsum_q  <= '0;
      c_q       <= '0;
    end else begin
      if (accept) begin
        a_q <= a_i;
        b_q <= b_i;
      end
      case (step)
        ST_HIGH: begin
          hi_prod_q <= mp[OP_W-1:0];
          asum_q    <= asum_d;
          bsum_q    <= bsum_d;
        end
        ST_LOW: begin
          lo_prod_q <= mp[OP_W-1:0];
          negsum_q  <= ~outer_sum + {{(PROD_W-1){1'b0}}, 1'b1};
        end
        ST_CROSS: begin
          c_q <= {top_part, lo_prod_q[HALF_W-1:0]};
        end
        default: ;
      endcase
    end
  end

  assign c_o = c_q;

  // Cross term minus outer products is a sum of two half products: below 2^(2H+1)
  assert_mid_fits_R1: assert property (@(posedge clk) disable iff (rst)
    (step == ST_CROSS) |-> (mid_term[PROD_W-1] == 1'b0));

  assert_low_fits_R7: assert property (@(posedge clk) disable iff (rst)
    (step == ST_LOW) |-> (mp[PROD_W-1:OP_W] == 2'b00));

  assert_operands_held_R3: assert property (@(posedge clk) disable iff (rst)
    (step == ST_HIGH || step == ST_LOW) |=> ($stable(a_q) && $stable(b_q)));

  assert_result_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(c_o));
endmodule

// File: tb/sim_karatsuba_mul256.sv
module sim_karatsuba_mul256;
  localparam int OPW = 256;
  localparam int RW  = 512;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [OPW-1:0] a_i = '0, b_i = '0;
  logic          busy_o, done_o;
  logic [RW-1:0] c_o;

  always #4 clk = ~clk;  // 125 MHz

  karatsuba_mul256 u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .a_i(a_i), .b_i(b_i),
    .busy_o(busy_o), .done_o(done_o), .c_o(c_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  // Behavioural reference model
  int            m_cnt = 0;
  int            q_cyc[$];
  logic [RW-1:0] q_val[$];
  logic [RW-1:0] last_c = '0;
  int            exp_done_cyc = -1;

  function automatic logic [RW-1:0] ref_mul(logic [OPW-1:0] x, logic [OPW-1:0] y);
    logic [RW-1:0] xw, yw;
    xw = {{OPW{1'b0}}, x};
    yw = {{OPW{1'b0}}, y};
    return xw * yw;
  endfunction

  function automatic logic [OPW-1:0] rnd256();
    logic [OPW-1:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0;
      cyc   = 0;
      q_cyc.delete();
      q_val.delete();
    end else begin
      cyc = cyc + 1;
      if (m_cnt == 0 && start_i) begin
        q_cyc.push_back(cyc + 3);
        q_val.push_back(ref_mul(a_i, b_i));
        m_cnt = 3;
      end else if (m_cnt > 0) begin
        m_cnt = m_cnt - 1;
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      logic exp_done;
      exp_done = (q_cyc.size() > 0) && (q_cyc[0] == cyc);
      checks++;
      if (done_o !== exp_done) begin
        errors++;
        $display("FAIL R2 cycle %0d done_o=%0b expected %0b", cyc, done_o, exp_done);
      end
      checks++;
      if (busy_o !== (m_cnt != 0)) begin
        errors++;
        $display("FAIL R6 cycle %0d busy_o=%0b expected %0b", cyc, busy_o, (m_cnt != 0));
      end
      if (exp_done) begin
        last_c = q_val[0];
        void'(q_cyc.pop_front());
        void'(q_val.pop_front());
        checks++;
        if (c_o !== last_c) begin
          errors++;
          $display("FAIL R1 cycle %0d c_o=%h expected %h", cyc, c_o, last_c);
        end
      end else begin
        checks++;
        if (c_o !== last_c) begin
          errors++;
          $display("FAIL R4 cycle %0d c_o=%h expected %h", cyc, c_o, last_c);
        end
      end
    end
  end

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  // Directed operation with its own result check
  task automatic run_op(input logic [OPW-1:0] a, input logic [OPW-1:0] b, input string tag);
    logic [RW-1:0] expv;
    int n;
    expv = ref_mul(a, b);
    wait_idle();
    a_i = a; b_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 10) begin
      @(negedge clk);
      n++;
    end
    checks++;
    if (c_o !== expv) begin
      errors++;
      $display("FAIL %s c_o=%h expected %h", tag, c_o, expv);
    end
  endtask

  logic [OPW-1:0] ones = '1;
  logic [OPW-1:0] zero = '0;

  initial begin
    repeat (3) @(negedge clk);
    // R5: outputs during reset
    checks++;
    if (busy_o !== 1'b0 || done_o !== 1'b0 || c_o !== '0) begin
      errors++;
      $display("FAIL R5 busy=%0b done=%0b c=%h expected 0 0 0", busy_o, done_o, c_o);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (busy_o !== 1'b0 || done_o !== 1'b0 || c_o !== '0) begin
      errors++;
      $display("FAIL R5 after release busy=%0b done=%0b c=%h expected 0 0 0", busy_o, done_o, c_o);
    end

    // R7 corner operands
    run_op(zero, zero, "R7 zero*zero");
    run_op(ones, ones, "R7 ones*ones");
    run_op(ones, zero, "R7 ones*zero");
    run_op(ones, 256'd1, "R7 ones*one");
    run_op({128'h0, {128{1'b1}}}, {{128{1'b1}}, 128'h0}, "R7 lo-ones*hi-ones");
    run_op({{128{1'b1}}, 128'h0}, {{128{1'b1}}, 128'h0}, "R7 hi-ones*hi-ones");
    run_op({128'h0, {128{1'b1}}}, {128'h0, {128{1'b1}}}, "R7 lo-ones*lo-ones");

    // R1 random operands
    for (int i = 0; i < 40; i++) run_op(rnd256(), rnd256(), "R1 random");

    // R3: start held high with other operands during busy
    begin
      logic [OPW-1:0] a1, b1;
      logic [RW-1:0] e1;
      a1 = rnd256(); b1 = rnd256(); e1 = ref_mul(a1, b1);
      wait_idle();
      a_i = a1; b_i = b1; start_i = 1'b1;
      @(negedge clk);
      a_i = rnd256(); b_i = rnd256();
      @(negedge clk);
      @(negedge clk);
      start_i = 1'b0;
      while (!done_o) @(negedge clk);
      checks++;
      if (c_o !== e1) begin
        errors++;
        $display("FAIL R3 c_o=%h expected %h", c_o, e1);
      end
      @(negedge clk);
      @(negedge clk);
      checks++;
      if (busy_o !== 1'b0) begin
        errors++;
        $display("FAIL R3 extra start accepted busy=%0b expected 0", busy_o);
      end
    end

    // R6: start held continuously, back-to-back acceptance on done cycles
    wait_idle();
    start_i = 1'b1;
    for (int i = 0; i < 24; i++) begin
      a_i = rnd256(); b_i = rnd256();
      @(negedge clk);
    end
    start_i = 1'b0;
    repeat (8) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule